// File: doc/BRIEF.md
# Packed Signed Quadword Greater-Than Unit

This block is a single-cycle SIMD execution slice that splits two source vectors into signed 64-bit lanes and tests, lane by lane, whether the first source is strictly greater than the second. The result is registered once and delivered in one of three forms, chosen by a mode input.

The first form is a lane-wide vector that merges into the old destination and leaves everything above bit 127 untouched. The second form is a lane-wide vector that clears every bit above the active length. The third form is a compact per-lane bit mask with a zeroing writemask. In that form the second operand may also be a single 64-bit value that every lane uses. Decode, operand fetch and fault handling belong to the surrounding pipeline.

Top module: `qgt_unit`

## Requirements
- R1: Each 64-bit lane j treats `src_a_i[64j+63:64j]` and its second operand as two's-complement integers and reports true only when the first is strictly greater. Equal values, most-negative against most-positive, and -1 against 0 all give false.
- R2: In both vector modes (`mode_i` 0 and 1), an active lane whose compare is true is written as 64 ones, and an active lane whose compare is false is written as 64 zeros.
- R3: With `mode_i` = 0 (merge), lanes 0 and 1 (bits 127:0) are written and all bits above 127 equal `old_dst_i`. `vlen_i`, the writemask and broadcast have no effect.
- R4: With `mode_i` = 1 (clear-upper), the active lane count is 2, 4 or 8 for `vlen_i` = 0, 1, or 2/3, capped at MAX_VL/64. All bits above the active lanes are 0.
- R5: With `mode_i` = 2 (mask), the active lane count follows the same `vlen_i` rule as R4. `mask_o[j]` carries lane j's compare, and mask bits at or above the active count are 0.
- R6: In mask mode with `wmask_en_i` = 1, any `mask_o[j]` whose `wmask_i[j]` is 0 is 0 (zeroing, never merging).
- R7: In mask mode with `wmask_en_i` = 0, `wmask_i` has no effect, as if it were all ones.
- R8: In mask mode with both `bcast_i` and `b_mem_i` = 1, every lane compares against `src_b_i[63:0]`. If either flag is 0, or the mode is not mask, each lane uses its own slice of `src_b_i`.
- R9: In mask mode `vec_o` is all zeros. In modes 0, 1 and 3, `mask_o` is all zeros. `mode_i` = 3 (reserved) drives both outputs to zero.
- R10: Outputs change one clock after the inputs are applied. While `rst_n` is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_i | input | MAX_VL | First source vector |
| src_b_i | input | MAX_VL | Second source vector (lane 0 holds the broadcast value) |
| old_dst_i | input | MAX_VL | Previous destination contents, used for merge mode |
| mode_i | input | 2 | 0 merge, 1 clear-upper, 2 mask, 3 reserved |
| vlen_i | input | 2 | 0: 128 bits, 1: 256 bits, 2/3: 512 bits |
| wmask_i | input | MAX_VL/64 | Writemask, one bit per lane |
| wmask_en_i | input | 1 | Applies the writemask in mask mode |
| bcast_i | input | 1 | Requests broadcast of the second operand |
| b_mem_i | input | 1 | Second operand comes from memory |
| vec_o | output | MAX_VL | Registered lane-wide result |
| mask_o | output | MAX_VL/64 | Registered per-lane mask result |

## Verification
One directed lane set pairs opposite-sign extremes, equal values, -1 against 0 and its mirror, and small neighbours. This set separates a signed comparison from an unsigned one, and strict greater-than from greater-or-equal. The set is replayed in every mode and vector length, which shows whether lane counts and clearing of the upper bits are right. Writemask and broadcast cases isolate zeroing from merging, and show that broadcast needs both flags. A long random run that mixes equal lanes and extreme values compares both outputs on every clock.

// File: rtl/qgt_pkg.sv
package qgt_pkg;
  localparam int LANE_W = 64;

  typedef enum logic [1:0] {
    QM_MERGE = 2'd0,
    QM_CLEAR = 2'd1,
    QM_MASK  = 2'd2,
    QM_NONE  = 2'd3
  } qmode_e;

  // Number of lanes selected by a vector-length code, capped at the build width.
  function automatic int lanes_for(input logic [1:0] vl, input int max_lanes);
    int n;
    case (vl)
      2'd0:    n = 2;
      2'd1:    n = 4;
      default: n = 8;
    endcase
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction
endpackage

// File: rtl/qgt_lane.sv
module qgt_lane #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o
);
  assign gt_o = $signed(a_i) > $signed(b_i);
endmodule

// File: rtl/qgt_bsel.sv
module qgt_bsel #(
  parameter int W     = 64,
  parameter int LANES = 8
) (
  input  logic [W*LANES-1:0] b_i,
  input  logic               use_scalar_i,
  output logic [W*LANES-1:0] b_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    if (j == 0) begin : g_base
      assign b_o[W-1:0] = b_i[W-1:0];
    end else begin : g_rest
      assign b_o[j*W +: W] = use_scalar_i ? b_i[W-1:0] : b_i[j*W +: W];
    end
  end
endmodule

// File: rtl/qgt_fmt.sv
module qgt_fmt
  import qgt_pkg::*;
#(
  parameter int W     = 64,
  parameter int LANES = 8
) (
  input  logic [LANES-1:0]   gt_i,
  input  qmode_e             mode_i,
  input  logic [1:0]         vlen_i,
  input  logic [LANES-1:0]   wmask_i,
  input  logic               wmask_en_i,
  input  logic [W*LANES-1:0] old_dst_i,
  output logic [W*LANES-1:0] vec_o,
  output logic [LANES-1:0]   mask_o
);
  int act;

  always_comb begin
    act = (mode_i == QM_MERGE) ? 2 : lanes_for(vlen_i, LANES);
    vec_o  = '0;
    mask_o = '0;
    for (int j = 0; j < LANES; j++) begin
      case (mode_i)
        QM_MERGE: vec_o[j*W +: W] = (j < act) ? {W{gt_i[j]}} : old_dst_i[j*W +: W];
        QM_CLEAR: vec_o[j*W +: W] = (j < act) ? {W{gt_i[j]}} : '0;
        QM_MASK:  mask_o[j] = (j < act) && gt_i[j] && (!wmask_en_i || wmask_i[j]);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/qgt_unit.sv
module qgt_unit
  import qgt_pkg::*;
#(
  parameter int MAX_VL = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [MAX_VL-1:0]        src_a_i,
  input  logic [MAX_VL-1:0]        src_b_i,
  input  logic [MAX_VL-1:0]        old_dst_i,
  input  logic [1:0]               mode_i,
  input  logic [1:0]               vlen_i,
  input  logic [MAX_VL/64-1:0]     wmask_i,
  input  logic                     wmask_en_i,
  input  logic                     bcast_i,
  input  logic                     b_mem_i,
  output logic [MAX_VL-1:0]        vec_o,
  output logic [MAX_VL/64-1:0]     mask_o
);
  localparam int LANES = MAX_VL / LANE_W;

  qmode_e               mode;
  logic                 use_scalar;
  logic [MAX_VL-1:0]    b_eff;
  logic [LANES-1:0]     gt;
  logic [MAX_VL-1:0]    vec_d, vec_q;
  logic [LANES-1:0]     mask_d, mask_q;
  logic                 upd_en;
  logic                 primed_q;

  assign mode       = qmode_e'(mode_i);
  assign use_scalar = bcast_i && b_mem_i && (mode == QM_MASK);
  assign upd_en     = 1'b1;

  qgt_bsel #(.W(LANE_W), .LANES(LANES)) u_bsel (
    .b_i(src_b_i), .use_scalar_i(use_scalar), .b_o(b_eff)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_cmp
    qgt_lane #(.W(LANE_W)) u_lane (
      .a_i(src_a_i[j*LANE_W +: LANE_W]),
      .b_i(b_eff[j*LANE_W +: LANE_W]),
      .gt_o(gt[j])
    );
  end

  qgt_fmt #(.W(LANE_W), .LANES(LANES)) u_fmt (
    .gt_i(gt), .mode_i(mode), .vlen_i(vlen_i), .wmask_i(wmask_i),
    .wmask_en_i(wmask_en_i), .old_dst_i(old_dst_i),
    .vec_o(vec_d), .mask_o(mask_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      mask_q <= '0;
    end else if (upd_en) begin
      vec_q  <= vec_d;
      mask_q <= mask_d;
    end
  end

  assign vec_o  = vec_q;
  assign mask_o = mask_q;

  // Marks that the output registers hold a value loaded from real inputs.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  if (MAX_VL > 128) begin : g_upper_chk
    assert_merge_keeps_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && $past(mode_i) == 2'd0) |-> vec_q[MAX_VL-1:128] == $past(old_dst_i[MAX_VL-1:128]));
    assert_clear_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && $past(mode_i) == 2'd1 && $past(vlen_i) == 2'd0) |-> vec_q[MAX_VL-1:128] == '0);
  end

  for (genvar j = 0; j < LANES; j++) begin : g_form_chk
    assert_lane_solid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (primed_q && $past(mode_i) == 2'd1) |->
        (vec_q[j*LANE_W +: LANE_W] == '0 || vec_q[j*LANE_W +: LANE_W] == '1));
  end

  assert_zeroing_wmask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $past(mode_i) == 2'd2 && $past(wmask_en_i)) |-> (mask_q & ~$past(wmask_i)) == '0);
  assert_vec_idle_in_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $past(mode_i) == 2'd2) |-> vec_q == '0);
  assert_mask_idle_in_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && $past(mode_i) != 2'd2) |-> mask_q == '0);
endmodule

// File: tb/sim_qgt_unit.sv
module sim_qgt_unit;
  localparam int VL = 512;
  localparam int ML = VL / 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VL-1:0] a, b, od;
  logic [1:0]    md, vl;
  logic [ML-1:0] wm;
  logic          we, bc, bm;
  logic [VL-1:0] vec;
  logic [ML-1:0] msk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qgt_unit #(.MAX_VL(VL)) u0 (
    .clk(clk), .rst_n(rst_n), .src_a_i(a), .src_b_i(b), .old_dst_i(od),
    .mode_i(md), .vlen_i(vl), .wmask_i(wm), .wmask_en_i(we), .bcast_i(bc),
    .b_mem_i(bm), .vec_o(vec), .mask_o(msk)
  );

  // Expected result queue: one entry per applied input set.
  logic [VL-1:0] q_vec[$];
  logic [ML-1:0] q_msk[$];
  string         q_tag[$];

  function automatic void ref_calc(output logic [VL-1:0] ev, output logic [ML-1:0] em);
    int act;
    longint signed x, y;
    if (md == 2'd0) act = 2;
    else act = (vl == 2'd0) ? 2 : (vl == 2'd1) ? 4 : 8;
    if (act > ML) act = ML;
    ev = (md == 2'd0) ? od : '0;
    em = '0;
    for (int j = 0; j < ML; j++) begin
      x = a[j*64 +: 64];
      y = (bc && bm && md == 2'd2) ? b[63:0] : b[j*64 +: 64];
      if (j < act) begin
        if (md == 2'd0 || md == 2'd1) ev[j*64 +: 64] = (x > y) ? '1 : '0;
        if (md == 2'd2 && x > y && (!we || wm[j])) em[j] = 1'b1;
      end
    end
  endfunction

  function automatic string mode_tag();
    case (md)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return we ? "R6" : "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic compare_head();
    logic [VL-1:0] ev;
    logic [ML-1:0] em;
    string t;
    if (q_vec.size() == 0) return;
    ev = q_vec.pop_front(); em = q_msk.pop_front(); t = q_tag.pop_front();
    n_chk++;
    if (vec !== ev) begin
      n_bad++;
      $display("FAIL %s vec actual=%h expected=%h", t, vec, ev);
    end
    n_chk++;
    if (msk !== em) begin
      n_bad++;
      $display("FAIL %s mask actual=%h expected=%h", t, msk, em);
    end
  endtask

  // Called after inputs are set at a negedge: compare the previous result, queue the new one.
  task automatic step(input string t);
    logic [VL-1:0] ev;
    logic [ML-1:0] em;
    compare_head();
    ref_calc(ev, em);
    q_vec.push_back(ev); q_msk.push_back(em); q_tag.push_back(t);
    @(negedge clk);
  endtask

  task automatic set_ctl(input logic [1:0] m, input logic [1:0] v, input logic [ML-1:0] w,
                         input logic e, input logic c, input logic mm);
    md = m; vl = v; wm = w; we = e; bc = c; bm = mm;
  endtask

  // Boundary lanes: MIN>MAX? no; MAX>MIN yes; equal; -1>0 no; 0>-1 yes; MIN=MIN; 1>0; -5>-6.
  task automatic load_edges();
    longint signed av[8] = '{64'sh8000000000000000, 64'sh7FFFFFFFFFFFFFFF, 5, -1, 0,
                            64'sh8000000000000000, 1, -5};
    longint signed bv[8] = '{64'sh7FFFFFFFFFFFFFFF, 64'sh8000000000000000, 5, 0, -1,
                            64'sh8000000000000000, 0, -6};
    for (int j = 0; j < ML; j++) begin
      a[j*64 +: 64] = av[j % 8];
      b[j*64 +: 64] = bv[j % 8];
      od[j*64 +: 64] = {32'hA5A5_0000 | 32'(j), 32'h5A5A_5A5A};
    end
  endtask

  task automatic rand_vecs();
    for (int w = 0; w < VL / 32; w++) begin
      a[w*32 +: 32] = $urandom; b[w*32 +: 32] = $urandom; od[w*32 +: 32] = $urandom;
    end
    for (int j = 0; j < ML; j++) begin
      case ($urandom % 6)
        0: b[j*64 +: 64] = a[j*64 +: 64];
        1: a[j*64 +: 64] = 64'h8000000000000000;
        2: b[j*64 +: 64] = 64'h7FFFFFFFFFFFFFFF;
        3: b[j*64 +: 64] = a[j*64 +: 64] - 64'd1;
        default: ;
      endcase
    end
  endtask

  initial begin
    a = '0; b = '0; od = '0;
    set_ctl(2'd0, 2'd0, '0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    // R10: reset state
    n_chk++;
    if (vec !== '0 || msk !== '0) begin
      n_bad++;
      $display("FAIL R10 reset actual=%h/%h expected=0/0", vec, msk);
    end
    rst_n = 1'b1;

    // R1 and R2: boundary lanes in every vector mode and length
    load_edges();
    for (int v = 0; v < 4; v++) begin
      set_ctl(2'd1, 2'(v), '0, 1'b0, 1'b0, 1'b0); step("R2");
      set_ctl(2'd0, 2'(v), '1, 1'b1, 1'b1, 1'b1); step("R3");
      set_ctl(2'd2, 2'(v), '1, 1'b0, 1'b0, 1'b0); step("R1");
      set_ctl(2'd2, 2'(v), 8'h00, 1'b0, 1'b0, 1'b0); step("R7");
      set_ctl(2'd2, 2'(v), 8'h5A, 1'b1, 1'b0, 1'b0); step("R6");
      set_ctl(2'd3, 2'(v), '1, 1'b0, 1'b0, 1'b0); step("R9");
    end
    // R8: broadcast needs both flags and mask mode
    load_edges();
    b[63:0] = 64'sd2;
    set_ctl(2'd2, 2'd2, '1, 1'b0, 1'b1, 1'b1); step("R8");
    set_ctl(2'd2, 2'd2, '1, 1'b0, 1'b1, 1'b0); step("R8");
    set_ctl(2'd2, 2'd2, '1, 1'b0, 1'b0, 1'b1); step("R8");
    set_ctl(2'd1, 2'd2, '1, 1'b0, 1'b1, 1'b1); step("R8");
    set_ctl(2'd2, 2'd1, 8'hF0, 1'b1, 1'b1, 1'b1); step("R8");

    // Random mix, checked every clock
    for (int i = 0; i < 3000; i++) begin
      rand_vecs();
      set_ctl(2'($urandom % 4), 2'($urandom % 4), ML'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom));
      step(mode_tag());
    end
    compare_head();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule